// File: doc/BRIEF.md
# Flag-Setting ALU with Branch Condition Evaluator

This block is the arithmetic/logic stage of a small accumulator-style processor. Each cycle it takes a 4-bit operation code and two operands, R (`opA`) and S (`opB`). It returns the operation's result combinationally. When the operation is accepted, it loads a four-bit flag register at the next rising clock edge. The supported operations are bitwise AND and OR, addition, subtraction, increment, decrement, and a compare. The compare runs the subtraction for its flags only and produces no result to write back.

A second part reads the stored flags and answers a branch question. Given a 4-bit condition code, it reports whether a jump should be taken. The conditions cover always, the raw zero, negative and carry flags, the unsigned relations and the signed relations. For the relational conditions to be meaningful, a compare or subtract of the two values must come first. Register selection and writeback stay outside the block; `resWrite` only tells the surrounding logic that `resOut` holds a value to store.

Top module: `alu_flag_unit`

## Requirements
- R1: With `opValid` high, code 0000 gives R AND S, 0001 gives R OR S, 0010 gives R+S, 0011 gives R-S, 0100 gives R+1 and 0101 gives R-1, all modulo 256, on `resOut` in the same cycle, with `resWrite` high.
- R2: Code 1000 (compare) loads the same flags as R-S at the clock edge but keeps `resWrite` low and `resOut` at zero.
- R3: Every accepted operation sets the zero flag (`flagsOut` bit 0) when its 8-bit result is zero, and sets the negative flag (bit 1) to bit 7 of that result.
- R4: Addition sets carry (bit 2) when R+S exceeds 255, and sets overflow (bit 3) when the sum of R and S, read as two's-complement numbers, falls outside -128..127.
- R5: Subtract and compare set carry when R >= S unsigned (no borrow), and set overflow when R-S, read as signed, falls outside -128..127.
- R6: Increment sets carry only when R is 255 and overflow only when R is 127. Decrement sets carry only when R is 0 and overflow only when R is 128.
- R7: AND and OR clear carry and overflow.
- R8: Reset clears all flags. Flags change only at a rising edge where `opValid` is high with a defined code. Undefined codes (0110, 0111, 1001 to 1111), or `opValid` low, leave the flags unchanged and hold `resWrite` low. `resOut` is zero whenever `resWrite` is low.
- R9: Condition 0 is always taken. Conditions 1, 2 and 3 are taken when the zero, negative and carry flags, respectively, are set.
- R10: After a compare or subtract of R and S, the conditions resolve as follows. Unsigned: 4 is R>S, 5 is R<S, 6 is R>=S, 7 is R<=S. Equality: 8 is taken when the zero flag is set.
- R11: After a compare or subtract of R and S, the signed conditions resolve as follows: 12 is R>S, 13 is R<S, 14 is R>=S, 15 is R<=S.
- R12: Condition codes 9, 10 and 11 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code |
| opA | input | 8 | Operand R |
| opB | input | 8 | Operand S |
| condCode | input | 4 | Branch condition to evaluate |
| resOut | output | 8 | Result, zero when not written |
| resWrite | output | 1 | Result should be stored |
| flagsOut | output | 4 | Stored flags: bit0 zero, bit1 negative, bit2 carry, bit3 overflow |
| takeBranch | output | 1 | Selected condition holds for the stored flags |

## Verification
On every cycle, the assertions check the following. The flags hold whenever no operation is accepted, and zero and negative follow the computed result. AND and OR clear carry and overflow. A compare never requests a write, and an idle result reads zero. Condition 0 is always taken and the unused codes are never taken. Only the bench's sweeps can show the correctness of the sums and differences, the carry and overflow values, and that the signed and unsigned relations match the true ordering of the operands. Those sweeps run every value of R against a spread of S values that includes the sign and wrap boundaries.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam logic [3:0] OP_AND = 4'h0;
  localparam logic [3:0] OP_OR  = 4'h1;
  localparam logic [3:0] OP_ADD = 4'h2;
  localparam logic [3:0] OP_SUB = 4'h3;
  localparam logic [3:0] OP_INC = 4'h4;
  localparam logic [3:0] OP_DEC = 4'h5;
  localparam logic [3:0] OP_CMP = 4'h8;

  localparam logic [3:0] CC_ALWAYS = 4'd0;
  localparam logic [3:0] CC_ZERO   = 4'd1;
  localparam logic [3:0] CC_NEG    = 4'd2;
  localparam logic [3:0] CC_CARRY  = 4'd3;
  localparam logic [3:0] CC_UGT    = 4'd4;
  localparam logic [3:0] CC_ULT    = 4'd5;
  localparam logic [3:0] CC_UGE    = 4'd6;
  localparam logic [3:0] CC_ULE    = 4'd7;
  localparam logic [3:0] CC_EQ     = 4'd8;
  localparam logic [3:0] CC_SGT    = 4'd12;
  localparam logic [3:0] CC_SLT    = 4'd13;
  localparam logic [3:0] CC_SGE    = 4'd14;
  localparam logic [3:0] CC_SLE    = 4'd15;

  // strobes from control to datapath
  typedef struct packed {
    logic useLogic;   // select bitwise unit instead of adder
    logic logicOr;    // OR instead of AND
    logic bConstOne;  // second adder input is constant one
    logic bInvert;    // invert second adder input
    logic carryIn;    // adder carry in
    logic carryFlip;  // report inverted carry out (borrow style)
    logic writeRes;   // result goes out for writeback
    logic setFlags;   // load flag register
  } aluStrobe_t;

  // stored flags, bit0 zero .. bit3 overflow
  typedef struct packed {
    logic ovf;
    logic carry;
    logic neg;
    logic zero;
  } aluFlags_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_flag_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output aluStrobe_t strb
);

  logic known;

  always_comb begin
    strb  = '0;
    known = 1'b1;
    case (opCode)
      OP_AND: strb.useLogic = 1'b1;
      OP_OR: begin
        strb.useLogic = 1'b1;
        strb.logicOr  = 1'b1;
      end
      OP_ADD: ;
      OP_SUB, OP_CMP: begin
        strb.bInvert = 1'b1;
        strb.carryIn = 1'b1;
      end
      OP_INC: strb.bConstOne = 1'b1;
      OP_DEC: begin
        strb.bConstOne = 1'b1;
        strb.bInvert   = 1'b1;
        strb.carryIn   = 1'b1;
        strb.carryFlip = 1'b1;
      end
      default: known = 1'b0;
    endcase
    strb.setFlags = opValid && known;
    strb.writeRes = opValid && known && (opCode != OP_CMP);
  end

endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  aluStrobe_t   strb,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output aluFlags_t    flagsQ
);

  localparam int MSB = W - 1;

  logic [W-1:0] bSrc;
  logic [W-1:0] bEff;
  logic [W-1:0] sum;
  logic         cOut;
  logic [W-1:0] logicRes;
  logic [W-1:0] core;
  aluFlags_t    flagsD;

  always_comb begin
    bSrc          = strb.bConstOne ? W'(1) : b;
    bEff          = strb.bInvert ? ~bSrc : bSrc;
    {cOut, sum}   = {1'b0, a} + {1'b0, bEff} + (W+1)'(strb.carryIn);
    logicRes      = strb.logicOr ? (a | b) : (a & b);
    core          = strb.useLogic ? logicRes : sum;
    flagsD.zero   = (core == '0);
    flagsD.neg    = core[MSB];
    flagsD.carry  = strb.useLogic ? 1'b0 : (cOut ^ strb.carryFlip);
    flagsD.ovf    = strb.useLogic ? 1'b0 :
                    ((a[MSB] == bEff[MSB]) && (sum[MSB] != a[MSB]));
    result        = strb.writeRes ? core : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             flagsQ <= '0;
    else if (strb.setFlags) flagsQ <= flagsD;
  end

  AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFlags |=> flagsQ.zero == ($past(core) == '0)); // R3
  AST_NEG_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFlags |=> flagsQ.neg == $past(core[MSB])); // R3
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setFlags && strb.useLogic) |=> (!flagsQ.carry && !flagsQ.ovf)); // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.setFlags |=> $stable(flagsQ)); // R8

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_flag_pkg::*;
(
  input  aluFlags_t  flg,
  input  logic [3:0] condCode,
  output logic       take
);

  logic sLess;

  always_comb begin
    sLess = flg.neg ^ flg.ovf;
    case (condCode)
      CC_ALWAYS: take = 1'b1;
      CC_ZERO:   take = flg.zero;
      CC_NEG:    take = flg.neg;
      CC_CARRY:  take = flg.carry;
      CC_UGT:    take = flg.carry && !flg.zero;
      CC_ULT:    take = !flg.carry;
      CC_UGE:    take = flg.carry;
      CC_ULE:    take = !flg.carry || flg.zero;
      CC_EQ:     take = flg.zero;
      CC_SGT:    take = !sLess && !flg.zero;
      CC_SLT:    take = sLess;
      CC_SGE:    take = !sLess;
      CC_SLE:    take = sLess || flg.zero;
      default:   take = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  logic [3:0]   opCode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [3:0]   condCode,
  output logic [W-1:0] resOut,
  output logic         resWrite,
  output logic [3:0]   flagsOut,
  output logic         takeBranch
);

  aluStrobe_t strb;
  aluFlags_t  flagsQ;

  alu_ctrl uCtrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strb    (strb)
  );

  alu_dpath #(.W(W)) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .a      (opA),
    .b      (opB),
    .result (resOut),
    .flagsQ (flagsQ)
  );

  alu_cond_eval uCond (
    .flg      (flagsQ),
    .condCode (condCode),
    .take     (takeBranch)
  );

  assign resWrite = strb.writeRes;
  assign flagsOut = flagsQ;

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |-> !resWrite); // R2
  AST_IDLE_RESULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !resWrite |-> (resOut == '0)); // R8
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == CC_ALWAYS) |-> takeBranch); // R9
  AST_UNUSED_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (condCode inside {4'd9, 4'd10, 4'd11}) |-> !takeBranch); // R12

endmodule

// File: tb/alu_flag_unit_test.sv
`timescale 1ns/10ps
module alu_flag_unit_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [3:0] opCode;
  logic [7:0] opA, opB;
  logic [3:0] condCode;
  logic [7:0] resOut;
  logic       resWrite;
  logic [3:0] flagsOut;
  logic       takeBranch;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  logic [3:0] expFlags;  // {ovf, carry, neg, zero}
  logic [7:0] bList [20];

  always #4 clk = ~clk;

  alu_flag_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .condCode(condCode), .resOut(resOut),
    .resWrite(resWrite), .flagsOut(flagsOut), .takeBranch(takeBranch)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns {known, write, res[7:0], flags[3:0]}
  function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [3:0] old);
    int sa, sb, r, sr;
    bit c, v, known;
    sa = $signed(a); sb = $signed(b);
    c = 0; v = 0; known = 1; r = 0;
    case (op)
      4'h0: r = a & b;
      4'h1: r = a | b;
      4'h2: begin r = a + b; c = (r > 255); sr = sa + sb; v = (sr > 127 || sr < -128); end
      4'h3, 4'h8: begin r = a - b; c = (a >= b); sr = sa - sb; v = (sr > 127 || sr < -128); end
      4'h4: begin r = a + 1; c = (a == 255); v = (a == 127); end
      4'h5: begin r = a - 1; c = (a == 0); v = (a == 128); end
      default: known = 0;
    endcase
    r = r & 255;
    if (!known) return {1'b0, 1'b0, 8'h00, old};
    return {1'b1, (op != 4'h8), 8'(r), v, c, r[7], (r == 0)};
  endfunction

  task automatic doOp(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                      input bit valid);
    logic [13:0] e;
    bit acc, isSub, expT;
    int sa, sb;
    @(negedge clk);
    opValid = valid; opCode = op; opA = a; opB = b;
    #1;
    e = model(op, a, b, expFlags);
    acc = valid && e[13];
    isSub = acc && (op == 4'h3 || op == 4'h8);
    check(resWrite == (acc && e[12]), "R2 R8 resWrite", resWrite, acc && e[12]);
    if (acc && e[12]) check(resOut == e[11:4], "R1 result", resOut, e[11:4]);
    else check(resOut == 8'h00, "R2 R8 idle result", resOut, 0);
    @(posedge clk);
    #1;
    if (acc) expFlags = e[3:0];
    check(flagsOut == expFlags, "R3 R4 R5 R6 R7 R8 flags", flagsOut, expFlags);
    sa = $signed(a); sb = $signed(b);
    for (int cc = 0; cc < 16; cc++) begin
      condCode = 4'(cc);
      #0.1;
      case (cc)
        0: check(takeBranch == 1'b1, "R9 always", takeBranch, 1);
        1: check(takeBranch == expFlags[0], "R9 zero", takeBranch, expFlags[0]);
        2: check(takeBranch == expFlags[1], "R9 neg", takeBranch, expFlags[1]);
        3: check(takeBranch == expFlags[2], "R9 carry", takeBranch, expFlags[2]);
        8: check(takeBranch == expFlags[0], "R10 equal", takeBranch, expFlags[0]);
        9, 10, 11: check(takeBranch == 1'b0, "R12 unused", takeBranch, 0);
        default: if (isSub) begin
          case (cc)
            4: expT = a > b;
            5: expT = a < b;
            6: expT = a >= b;
            7: expT = a <= b;
            12: expT = sa > sb;
            13: expT = sa < sb;
            14: expT = sa >= sb;
            default: expT = sa <= sb;
          endcase
          if (cc < 8) check(takeBranch == expT, "R10 unsigned relation", takeBranch, expT);
          else check(takeBranch == expT, "R11 signed relation", takeBranch, expT);
        end
      endcase
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  initial begin
    logic [3:0] ops [7];
    ops = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h8};
    for (int k = 0; k < 16; k++) bList[k] = 8'((k * 13) % 256);
    bList[16] = 8'h7F; bList[17] = 8'h80; bList[18] = 8'hFF; bList[19] = 8'h01;
    rstN = 0; opValid = 0; opCode = 0; opA = 0; opB = 0; condCode = 0;
    expFlags = 4'h0;
    repeat (3) @(posedge clk);
    #1;
    check(flagsOut == 4'h0, "R8 reset flags", flagsOut, 0);
    condCode = 4'd0; #0.1;
    check(takeBranch == 1'b1, "R9 always after reset", takeBranch, 1);
    condCode = 4'd5; #0.1;
    check(takeBranch == 1'b1, "R10 no carry after reset", takeBranch, 1);
    @(negedge clk);
    rstN = 1;

    // corner cases named explicitly
    doOp(4'h2, 8'd89, 8'd144, 1);   // R4 sum 233 no carry
    doOp(4'h2, 8'd144, 8'd233, 1);  // R4 carry past 255
    doOp(4'h4, 8'hFF, 8'h00, 1);    // R6 increment wrap
    doOp(4'h5, 8'h00, 8'h00, 1);    // R6 decrement borrow
    doOp(4'h4, 8'h7F, 8'h00, 1);    // R6 signed overflow
    doOp(4'h5, 8'h80, 8'h00, 1);    // R6 signed overflow
    doOp(4'h8, 8'h05, 8'h05, 1);    // R2 equal compare
    doOp(4'h2, 8'h12, 8'h34, 0);    // R8 invalid cycle holds flags
    for (int u = 6; u < 16; u++)
      if (u != 8) doOp(4'(u), 8'h00, 8'h00, 1);  // R8 undefined codes

    // sweeps
    for (int o = 0; o < 7; o++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 20; j++)
          doOp(ops[o], 8'(a), bList[j], 1);

    finishRun();
  end

endmodule